// File: doc/BRIEF.md
# Branch and Jump Resolution Unit

This block decides where an RV64 integer core fetches next after a conditional branch or a direct jump-and-link. It is purely combinational. It takes the 32-bit instruction word, the current program counter and the two register operands already read for the instruction's source fields. It rebuilds the scrambled PC-relative offset of the branch or jump format, evaluates the compare that `funct3` selects, and produces the next PC.

For jump-and-link it also drives a register write port: an enable, the destination index and the return address. The enable is held low when the destination is register zero, so a plain jump never disturbs the hard-wired zero register. A redirect flag tells a later stage, for example a counter stage, whether control left the sequential path. Any other opcode falls through to PC+4 and writes nothing.

Top module: `rvbr_resolve`

## Requirements
- R1: The opcode is `instr_i[6:0]`. For any opcode other than 7'h63 (branch) and 7'h6F (jump-and-link), `next_pc_o` = `pc_i`+4 modulo 2^64, and `taken_o`, `link_we_o` and `illegal_o` are all 0.
- R2: For opcode 7'h63 the offset is {bit31, bit7, bits[30:25], bits[11:8], 0}, sign-extended from its bit 12. A taken branch gives `next_pc_o` = `pc_i` + offset (modulo 2^64), so a negative offset moves backwards. The range is -4096 to +4094.
- R3: A branch that is not taken gives `next_pc_o` = `pc_i`+4 and `taken_o` = 0. A taken branch gives `taken_o` = 1.
- R4: `funct3` is `instr_i[14:12]`. `funct3`=0 takes the branch when the operands are equal, and `funct3`=1 takes it when they differ. Operand A comes from the `instr_i[19:15]` field and operand B from the `instr_i[24:20]` field.
- R5: `funct3`=4 takes the branch when A < B as signed 64-bit values, and `funct3`=5 takes it when A >= B as signed values.
- R6: `funct3`=6 takes the branch when A < B as unsigned values, and `funct3`=7 takes it when A >= B as unsigned values.
- R7: On opcode 7'h63 with `funct3` 2 or 3, `illegal_o` = 1, `taken_o` = 0, `next_pc_o` = `pc_i`+4 and `link_we_o` = 0.
- R8: For opcode 7'h6F the offset is {bit31, bits[19:12], bit20, bits[30:21], 0}, sign-extended from its bit 20. The jump always gives `next_pc_o` = `pc_i` + offset and `taken_o` = 1. The range is -1048576 to +1048574.
- R9: Jump-and-link with rd = `instr_i[11:7]` nonzero gives `link_we_o` = 1. `link_idx_o` always equals `instr_i[11:7]` and `link_val_o` always equals `pc_i`+4.
- R10: Jump-and-link with rd = 0 gives `link_we_o` = 0, and the jump still happens.
- R11: The branch opcode never asserts `link_we_o`, whatever the operands or `funct3`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr_i | input | 32 | Instruction word |
| pc_i | input | 64 | Address of the instruction |
| src_a_i | input | 64 | First source operand (field [19:15]) |
| src_b_i | input | 64 | Second source operand (field [24:20]) |
| next_pc_o | output | 64 | Address to fetch next |
| taken_o | output | 1 | Control leaves the sequential path |
| link_we_o | output | 1 | Return-address write enable |
| link_idx_o | output | 5 | Return-address destination index |
| link_val_o | output | 64 | Return address (PC+4) |
| illegal_o | output | 1 | Reserved compare code on the branch opcode |

## Verification
The bench drives the extreme offsets of both formats: the largest forward and the most negative backward displacement. A design that dropped or misplaced a scrambled bit, or that sign-extended from the wrong position, would land on the wrong target there. It compares operands whose top bits differ, where the signed and unsigned compares must give opposite answers, so a design that swapped the two compare flavours gives itself away. Jumps that target register zero check that the write is suppressed while the redirect still happens. A PC near the top of the address space checks that the fall-through wraps. The reserved compare codes must fall through and raise the illegal flag.

// File: rtl/rvbr_pkg.sv
package rvbr_pkg;
  localparam int ILEN = 32;
  localparam int RIDX_W = 5;
  localparam logic [6:0] OPC_BRANCH = 7'h63;
  localparam logic [6:0] OPC_JAL    = 7'h6F;

  typedef enum logic [2:0] {
    CMP_EQ  = 3'd0,
    CMP_NE  = 3'd1,
    CMP_RS2 = 3'd2,
    CMP_RS3 = 3'd3,
    CMP_LT  = 3'd4,
    CMP_GE  = 3'd5,
    CMP_LTU = 3'd6,
    CMP_GEU = 3'd7
  } cmp_e;

  typedef struct packed {
    logic [6:0]        opc;
    logic [RIDX_W-1:0] rd;
    logic [2:0]        f3;
    logic [RIDX_W-1:0] ra;
    logic [RIDX_W-1:0] rb;
  } ifields_t;

  function automatic ifields_t split_fields(input logic [ILEN-1:0] w);
    ifields_t f;
    f.opc = w[6:0];
    f.rd  = w[11:7];
    f.f3  = w[14:12];
    f.ra  = w[19:15];
    f.rb  = w[24:20];
    return f;
  endfunction
endpackage

// File: rtl/rvbr_offset_gen.sv
module rvbr_offset_gen
  import rvbr_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [ILEN-1:0] instr_i,
  output logic [XLEN-1:0] br_off_o,
  output logic [XLEN-1:0] jmp_off_o
);
  localparam int BR_W  = 13;
  localparam int JMP_W = 21;

  logic [BR_W-1:0]  br_raw;
  logic [JMP_W-1:0] jmp_raw;

  always_comb begin
    br_raw  = {instr_i[31], instr_i[7], instr_i[30:25], instr_i[11:8], 1'b0};
    jmp_raw = {instr_i[31], instr_i[19:12], instr_i[20], instr_i[30:21], 1'b0};
  end

  generate
    if (XLEN > JMP_W) begin : g_sext
      assign br_off_o  = {{(XLEN-BR_W){br_raw[BR_W-1]}}, br_raw};
      assign jmp_off_o = {{(XLEN-JMP_W){jmp_raw[JMP_W-1]}}, jmp_raw};
    end else begin : g_bad_width
      assign br_off_o  = XLEN'(br_raw);
      assign jmp_off_o = XLEN'(jmp_raw);
    end
  endgenerate

  // Sign of both offsets must follow the instruction's top bit (R2, R8)
  always_comb begin
    p_sign_follow_r2: assert (br_off_o[XLEN-1] == instr_i[31])
      else $error("branch offset sign lost");
    p_sign_follow_r8: assert (jmp_off_o[XLEN-1] == instr_i[31])
      else $error("jump offset sign lost");
  end
endmodule

// File: rtl/rvbr_cond_eval.sv
module rvbr_cond_eval
  import rvbr_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [2:0]      f3_i,
  input  logic [XLEN-1:0] src_a_i,
  input  logic [XLEN-1:0] src_b_i,
  output logic            hit_o,
  output logic            rsvd_o
);
  logic eq, lt_s, lt_u, base;
  cmp_e code;

  always_comb begin
    code = cmp_e'(f3_i);
    eq   = (src_a_i == src_b_i);
    lt_s = ($signed(src_a_i) < $signed(src_b_i));
    lt_u = (src_a_i < src_b_i);
    rsvd_o = (code == CMP_RS2) || (code == CMP_RS3);
    // bit 2 picks magnitude vs equality, bit 1 picks unsigned, bit 0 inverts
    if (!f3_i[2])     base = eq;
    else if (f3_i[1]) base = lt_u;
    else              base = lt_s;
    hit_o = rsvd_o ? 1'b0 : (base ^ f3_i[0]);
  end
endmodule

// File: rtl/rvbr_resolve.sv
module rvbr_resolve
  import rvbr_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [ILEN-1:0]   instr_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic [XLEN-1:0]   src_a_i,
  input  logic [XLEN-1:0]   src_b_i,
  output logic [XLEN-1:0]   next_pc_o,
  output logic              taken_o,
  output logic              link_we_o,
  output logic [RIDX_W-1:0] link_idx_o,
  output logic [XLEN-1:0]   link_val_o,
  output logic              illegal_o
);
  localparam logic [XLEN-1:0] STEP = XLEN'(4);

  ifields_t        fld;
  logic [XLEN-1:0] br_off, jmp_off, sel_off, seq_pc, tgt_pc;
  logic            is_br, is_jal, hit, rsvd;

  rvbr_offset_gen #(.XLEN(XLEN)) u_off (
    .instr_i   (instr_i),
    .br_off_o  (br_off),
    .jmp_off_o (jmp_off)
  );

  rvbr_cond_eval #(.XLEN(XLEN)) u_cmp (
    .f3_i    (fld.f3),
    .src_a_i (src_a_i),
    .src_b_i (src_b_i),
    .hit_o   (hit),
    .rsvd_o  (rsvd)
  );

  always_comb begin
    fld     = split_fields(instr_i);
    is_br   = (fld.opc == OPC_BRANCH);
    is_jal  = (fld.opc == OPC_JAL);
    sel_off = is_jal ? jmp_off : br_off;
    seq_pc  = pc_i + STEP;
    tgt_pc  = pc_i + sel_off;
  end

  always_comb begin
    taken_o    = is_jal | (is_br & hit);
    illegal_o  = is_br & rsvd;
    link_we_o  = is_jal & (fld.rd != '0);
    link_idx_o = fld.rd;
    link_val_o = seq_pc;
    next_pc_o  = taken_o ? tgt_pc : seq_pc;
  end

  always_comb begin
    p_x0_kept_r10: assert (!link_we_o || (instr_i[11:7] != '0))
      else $error("link write aimed at register zero");
    p_rsvd_fall_r7: assert (!illegal_o || (!taken_o && next_pc_o == pc_i + STEP))
      else $error("reserved compare redirected");
    p_fallthru_r3: assert (taken_o || (next_pc_o == pc_i + STEP))
      else $error("sequential path not PC+4");
    p_no_br_link_r11: assert (!(link_we_o && instr_i[6:0] == OPC_BRANCH))
      else $error("branch wrote a link");
    p_other_quiet_r1: assert ((instr_i[6:0] == OPC_BRANCH) || (instr_i[6:0] == OPC_JAL)
                              || !(taken_o || link_we_o || illegal_o))
      else $error("unrelated opcode had side effects");
  end
endmodule

// File: tb/rvbr_resolve_tb_top.sv
module rvbr_resolve_tb_top;
  logic        clk;
  logic [31:0] instr;
  logic [63:0] pc, a, b;
  logic [63:0] next_pc, link_val;
  logic        taken, link_we, illegal;
  logic [4:0]  link_idx;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  logic [63:0] e_pc, e_val;
  logic        e_tk, e_we, e_il;
  logic [4:0]  e_idx;

  rvbr_resolve dut_i (
    .instr_i(instr), .pc_i(pc), .src_a_i(a), .src_b_i(b),
    .next_pc_o(next_pc), .taken_o(taken), .link_we_o(link_we),
    .link_idx_o(link_idx), .link_val_o(link_val), .illegal_o(illegal)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic logic [31:0] enc_b(input int off, input logic [2:0] f3);
    logic [12:0] o;
    o = off[12:0];
    return {o[12], o[10:5], 5'd2, 5'd1, f3, o[4:1], o[11], 7'h63};
  endfunction

  function automatic logic [31:0] enc_j(input int off, input logic [4:0] rd);
    logic [20:0] o;
    o = off[20:0];
    return {o[20], o[10:1], o[11], o[19:12], rd, 7'h6F};
  endfunction

  // Behavioural reference built from the requirements
  task automatic model();
    longint off;
    logic   go;
    e_pc = pc + 64'd4; e_tk = 0; e_we = 0; e_il = 0;
    e_idx = instr[11:7]; e_val = pc + 64'd4;
    if (instr[6:0] == 7'h63) begin
      off = (instr[31] ? -4096 : 0) + longint'(instr[7]) * 2048
          + longint'(instr[30:25]) * 32 + longint'(instr[11:8]) * 2;
      go = 0;
      case (instr[14:12])
        3'd0: go = (a == b);
        3'd1: go = (a != b);
        3'd4: go = ($signed(a) < $signed(b));
        3'd5: go = ($signed(a) >= $signed(b));
        3'd6: go = (a < b);
        3'd7: go = (a >= b);
        default: e_il = 1;
      endcase
      if (go) begin e_tk = 1; e_pc = pc + 64'(off); end
    end else if (instr[6:0] == 7'h6F) begin
      off = (instr[31] ? -1048576 : 0) + longint'(instr[19:12]) * 4096
          + longint'(instr[20]) * 2048 + longint'(instr[30:21]) * 2;
      e_tk = 1; e_pc = pc + 64'(off);
      e_we = (instr[11:7] != 0);
    end
  endtask

  task automatic apply(input string tag, input logic [31:0] iw,
                       input logic [63:0] p, input logic [63:0] va, input logic [63:0] vb);
    @(posedge clk);
    instr = iw; pc = p; a = va; b = vb;
    model();
    @(negedge clk);
    checks = checks + 1;
    if (next_pc !== e_pc) begin
      errors = errors + 1;
      $display("FAIL %s next_pc: actual=%h expected=%h", tag, next_pc, e_pc);
    end
    checks = checks + 1;
    if ({taken, illegal, link_we, link_idx, link_val} !== {e_tk, e_il, e_we, e_idx, e_val}) begin
      errors = errors + 1;
      $display("FAIL %s flags tk/il/we/idx/val: actual=%b%b%b %0d %h expected=%b%b%b %0d %h",
               tag, taken, illegal, link_we, link_idx, link_val,
               e_tk, e_il, e_we, e_idx, e_val);
    end
  endtask

  localparam logic [63:0] BASE = 64'h0000_0000_8000_1000;
  localparam logic [63:0] NEG1 = 64'hFFFF_FFFF_FFFF_FFFF;

  initial begin
    instr = '0; pc = '0; a = '0; b = '0;
    // quiet state at start: all-zero word is an unrelated opcode (R1)
    apply("R1 idle", 32'h0, 64'h0, 64'h0, 64'h0);
    apply("R1 addi", 32'h0630_0293, BASE, 64'd5, 64'd5);
    apply("R1 wrap", 32'h0000_0013, 64'hFFFF_FFFF_FFFF_FFFC, 64'd0, 64'd0);
    // R4 equal/not equal
    apply("R4 eq hit", enc_b(64, 3'd0), BASE, 64'd7, 64'd7);
    apply("R4 eq miss", enc_b(64, 3'd0), BASE, 64'd7, 64'd8);
    apply("R4 ne hit", enc_b(-8, 3'd1), BASE, 64'd7, 64'd8);
    // R2 extremes
    apply("R2 max fwd", enc_b(4094, 3'd0), BASE, 64'd1, 64'd1);
    apply("R2 max back", enc_b(-4096, 3'd0), BASE, 64'd1, 64'd1);
    apply("R3 not taken", enc_b(-4096, 3'd1), BASE, 64'd1, 64'd1);
    // R5 / R6 with differing top bits: -1 vs 1
    apply("R5 lt signed", enc_b(100, 3'd4), BASE, NEG1, 64'd1);
    apply("R5 ge signed", enc_b(100, 3'd5), BASE, NEG1, 64'd1);
    apply("R6 ltu", enc_b(100, 3'd6), BASE, NEG1, 64'd1);
    apply("R6 geu", enc_b(100, 3'd7), BASE, NEG1, 64'd1);
    apply("R5 ge equal", enc_b(-2, 3'd5), BASE, NEG1, NEG1);
    apply("R6 ltu equal", enc_b(-2, 3'd6), BASE, 64'd9, 64'd9);
    // R7 reserved codes
    apply("R7 f3=2", enc_b(40, 3'd2), BASE, 64'd0, 64'd0);
    apply("R7 f3=3", enc_b(40, 3'd3), BASE, NEG1, 64'd0);
    // R8/R9/R10 jumps
    apply("R8 max fwd", enc_j(1048574, 5'd1), BASE, 64'd0, 64'd0);
    apply("R8 max back", enc_j(-1048576, 5'd1), BASE, 64'd0, 64'd0);
    apply("R9 link rd5", enc_j(2048, 5'd5), BASE, 64'd0, 64'd0);
    apply("R10 rd zero", enc_j(-2, 5'd0), BASE, 64'd0, 64'd0);
    apply("R11 branch rd bits", enc_b(2, 3'd0) | 32'h0000_0000, BASE, 64'd3, 64'd3);
    // random sweep
    for (int i = 0; i < 400; i++) begin
      logic [31:0] w;
      logic [63:0] ra, rb;
      w  = $urandom;
      case (i % 4)
        0: w[6:0] = 7'h63;
        1: w[6:0] = 7'h6F;
        2: w[6:0] = 7'h63;
        default: ;
      endcase
      ra = {$urandom, $urandom};
      rb = (i % 5 == 0) ? ra : {$urandom, $urandom};
      apply(w[6:0] == 7'h63 ? "R2 rnd branch" : (w[6:0] == 7'h6F ? "R8 rnd jump" : "R1 rnd other"),
            w, {$urandom, $urandom}, ra, rb);
    end
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule